// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register Core

This block holds the digital state of a four-channel, 16-bit converter. A front-end serial decoder hands it one decoded write per completed frame: a channel number and a 16-bit code. Each channel keeps two registers. The input register takes every write. The output latch drives the parallel code output that feeds the converter. A write either moves straight through to the latch or waits in the input register. The choice depends on the level of an active-low load pin at the moment the write arrives.

Waiting codes move into their latches on a load event. A load event is either a falling edge on the load pin or a command write with its load bit set. Only channels written since the previous load event are moved, so a channel that was not touched never sees its latch rewritten. A hardware reset input clears the block. A self-clearing reset bit in the command word does the same job in software.

Top module: `dbd_dac_core`

## Requirements
- R1: After hardware reset every channel's output code is 0000h.
- R2: A write to channel `c` (`wr_chan` = c, 0 to 3) affects only channel `c`. The codes of the other channels stay unchanged.
- R3: A write accepted while the synchronized load pin is low sets both the input register and the latch of the addressed channel. The new code appears on the output one clock after the write strobe.
- R4: A write accepted while the synchronized load pin is high changes only the input register. The channel's output code does not change.
- R5: A command write with `cmd_load_bit` = 1, or a falling edge of `load_n`, copies each waiting input register into its latch.
- R6: A load event leaves the latch of every channel with no pending write unchanged.
- R7: While `rst_n` is low, all codes read 0000h and write strobes are ignored. After `rst_n` rises, the codes stay 0000h until a new code is written and loaded.
- R8: A write held waiting across a hardware reset is discarded. A later load event does not bring it back.
- R9: A command write with `cmd_reset_bit` = 1 raises `rst_busy` for exactly one clock. It then clears all codes and discards all waiting writes. Writes presented while `rst_busy` is high are ignored.
- R10: After hardware or software reset every bit of `gain_sel` is 1. A command write without the reset bit loads `gain_sel` from `cmd_gain`.
- R11: A deferred write in the same cycle as a load event stays pending. That load moves the channel's previous pending code. The next load moves the new code.
- R12: `load_n` passes through a two-flop synchronizer. A falling edge changes the latches three clocks after the pin falls, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| load_n | input | 1 | Load pin, active low, asynchronous to clk |
| wr_valid | input | 1 | One-cycle strobe for a decoded channel write |
| wr_chan | input | 2 | Channel addressed by the write |
| wr_code | input | 16 | Code carried by the write |
| cmd_wr | input | 1 | One-cycle strobe for a command-word write |
| cmd_load_bit | input | 1 | Load bit of the command word |
| cmd_reset_bit | input | 1 | Software reset bit of the command word |
| cmd_gain | input | 4 | Gain bits of the command word, one per channel |
| dac_code | output | 64 | Latch codes, channel c at bits [16c+15:16c] |
| gain_sel | output | 4 | Current gain bits |
| rst_busy | output | 1 | Software reset bit, high for the one cycle it is in effect |

## Verification
The bench aims at the cases where the two registers of a channel disagree.

**Deferred write without a load.** A core that treats every write as immediate changes the output code too early.

**Write and load in the same cycle.** A core that clears the pending flag on the load loses the newer code. A core that passes the newer code straight through skips the queued one.

**Loads on channels with nothing pending.** These show whether clean channels are rewritten.

**Writes during either reset.** These show whether resets really block the input side.

**Load pin timing.** The load pin is probed one cycle before and one cycle after its synchronized edge should act. A missing or extra synchronizer stage shows up there as a latch change in the wrong cycle.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

  localparam int unsigned DBD_NCH = 4;
  localparam int unsigned DBD_CW  = 16;

  // Classification of a channel write at the moment it is accepted.
  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_IMM   = 2'd1,
    WK_DEFER = 2'd2
  } wr_kind_e;

  // A write is dropped while a reset is in effect; otherwise the synchronized
  // load level decides whether it goes through to the latch at once.
  function automatic wr_kind_e classify_write(input logic valid,
                                              input logic blocked,
                                              input logic load_lvl_n);
    if (!valid || blocked) return WK_NONE;
    if (!load_lvl_n)       return WK_IMM;
    return WK_DEFER;
  endfunction

  // Next latch value given the write and load situation of one channel.
  function automatic logic [DBD_CW-1:0] next_latch(input wr_kind_e   kind,
                                                   input logic       hit,
                                                   input logic       load,
                                                   input logic       pending,
                                                   input logic [DBD_CW-1:0] code,
                                                   input logic [DBD_CW-1:0] inreg,
                                                   input logic [DBD_CW-1:0] latch);
    if (hit && kind == WK_IMM) return code;
    if (load && pending)       return inreg;
    return latch;
  endfunction

  // Next pending flag of one channel.
  function automatic logic next_pending(input wr_kind_e kind,
                                        input logic     hit,
                                        input logic     load,
                                        input logic     pending);
    if (hit && kind == WK_DEFER) return 1'b1;
    if (hit && kind == WK_IMM)   return 1'b0;
    if (load)                    return 1'b0;
    return pending;
  endfunction

endpackage

// File: rtl/dbd_load_sync.sv
module dbd_load_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl_n_o,
  output logic fall_o
);
  logic meta_q;
  logic sync_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= pin_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_n_o = sync_q;
  assign fall_o  = prev_q & ~sync_q;

  // R12: a detected edge is a single-cycle pulse
  p_fall_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

  // R12: the synchronized level lags the pin by two flops
  p_sync_lag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_n) == 1'b0 && pin_n == 1'b0) |=> !lvl_n_o);

endmodule

// File: rtl/dbd_cmd_ctl.sv
module dbd_cmd_ctl #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic           cmd_load_bit,
  input  logic           cmd_reset_bit,
  input  logic [NCH-1:0] cmd_gain,
  output logic           load_cmd_o,
  output logic           soft_rst_o,
  output logic [NCH-1:0] gain_o
);
  localparam logic [NCH-1:0] GAIN_DEFAULT = '1;

  logic           soft_q;
  logic [NCH-1:0] gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= 1'b0;
      gain_q <= GAIN_DEFAULT;
    end else begin
      soft_q <= cmd_wr & cmd_reset_bit & ~soft_q;
      if (soft_q)                       gain_q <= GAIN_DEFAULT;
      else if (cmd_wr && !cmd_reset_bit) gain_q <= cmd_gain;
    end
  end

  assign load_cmd_o = cmd_wr & cmd_load_bit & ~soft_q;
  assign soft_rst_o = soft_q;
  assign gain_o     = gain_q;

  // R9: the reset bit clears itself after one cycle
  p_soft_selfclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> !soft_q);

  // R10: gain bits return to all ones after a software reset
  p_gain_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> (gain_q == GAIN_DEFAULT));

endmodule

// File: rtl/dbd_channel.sv
module dbd_channel
  import dbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  wr_kind_e          kind,
  input  logic              hit,
  input  logic              load,
  input  logic [DBD_CW-1:0] code,
  output logic [DBD_CW-1:0] latch_o,
  output logic              pending_o
);
  logic [DBD_CW-1:0] inreg_q;
  logic [DBD_CW-1:0] latch_q;
  logic              pend_q;
  logic              wr_here;

  assign wr_here = hit && (kind != WK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inreg_q <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else if (clr) begin
      inreg_q <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_here) inreg_q <= code;
      latch_q <= next_latch(kind, hit, load, pend_q, code, inreg_q, latch_q);
      pend_q  <= next_pending(kind, hit, load, pend_q);
    end
  end

  assign latch_o   = latch_q;
  assign pending_o = pend_q;

  // R3: immediate write reaches the latch on the next cycle
  p_imm_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == WK_IMM && !clr) |=> (latch_q == $past(code)));

  // R4: deferred write without a load leaves the latch alone
  p_defer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == WK_DEFER && !load && !clr) |=> $stable(latch_q));

  // R6: a load on a clean channel leaves its latch alone
  p_clean_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !pend_q && !wr_here && !clr) |=> $stable(latch_q));

  // R11: a deferred write concurrent with a load stays pending
  p_pending_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == WK_DEFER && !clr) |=> pend_q);

  // R9: a clear empties the channel
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (latch_q == '0 && !pend_q));

endmodule

// File: rtl/dbd_dac_core.sv
module dbd_dac_core
  import dbd_pkg::*;
#(
  parameter int unsigned NCH = DBD_NCH,
  parameter int unsigned CW  = DBD_CW,
  localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_chan,
  input  logic [CW-1:0]     wr_code,
  input  logic              cmd_wr,
  input  logic              cmd_load_bit,
  input  logic              cmd_reset_bit,
  input  logic [NCH-1:0]    cmd_gain,
  output logic [NCH*CW-1:0] dac_code,
  output logic [NCH-1:0]    gain_sel,
  output logic              rst_busy
);
  // Named internal events, brought out for the assertions.
  logic     load_lvl_n;
  logic     pin_fall;
  logic     load_cmd;
  logic     soft_rst;
  logic     load_evt;
  wr_kind_e wr_kind;
  logic [NCH-1:0] chan_pending;

  dbd_load_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (load_n),
    .lvl_n_o (load_lvl_n),
    .fall_o  (pin_fall)
  );

  dbd_cmd_ctl #(.NCH(NCH)) u_cmd (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wr        (cmd_wr),
    .cmd_load_bit  (cmd_load_bit),
    .cmd_reset_bit (cmd_reset_bit),
    .cmd_gain      (cmd_gain),
    .load_cmd_o    (load_cmd),
    .soft_rst_o    (soft_rst),
    .gain_o        (gain_sel)
  );

  assign wr_kind  = classify_write(wr_valid, soft_rst, load_lvl_n);
  assign load_evt = (pin_fall | load_cmd) & ~soft_rst;
  assign rst_busy = soft_rst;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    logic hit;
    assign hit = (wr_chan == AW'(gi));
    dbd_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst),
      .kind      (wr_kind),
      .hit       (hit),
      .load      (load_evt),
      .code      (wr_code),
      .latch_o   (dac_code[gi*CW +: CW]),
      .pending_o (chan_pending[gi])
    );
  end

  // R2: at most one channel gains a pending write per cycle
  p_one_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(chan_pending & ~$past(chan_pending)) <= 1));

  // R5: after a load event only concurrently written channels stay pending
  p_load_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && wr_kind == WK_NONE) |=> (chan_pending == '0));

  // R9: writes are blocked while the software reset is in effect
  p_block_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (wr_kind == WK_NONE));

endmodule

// File: tb/dbd_dac_core_bench.sv
module dbd_dac_core_bench;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_n = 1'b1;
  logic              wr_valid = 1'b0;
  logic [1:0]        wr_chan = '0;
  logic [CW-1:0]     wr_code = '0;
  logic              cmd_wr = 1'b0;
  logic              cmd_load_bit = 1'b0;
  logic              cmd_reset_bit = 1'b0;
  logic [NCH-1:0]    cmd_gain = '1;
  logic [NCH*CW-1:0] dac_code;
  logic [NCH-1:0]    gain_sel;
  logic              rst_busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  logic [NCH-1:0] gain_model = '1;

  dbd_dac_core u_dbd_dac_core (
    .clk(clk), .rst_n(rst_n), .load_n(load_n),
    .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_code(wr_code),
    .cmd_wr(cmd_wr), .cmd_load_bit(cmd_load_bit), .cmd_reset_bit(cmd_reset_bit),
    .cmd_gain(cmd_gain), .dac_code(dac_code), .gain_sel(gain_sel), .rst_busy(rst_busy)
  );

  always #4 clk = ~clk;

  function automatic logic [CW-1:0] code_of(input int ch);
    return dac_code[ch*CW +: CW];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [CW-1:0] e0, input logic [CW-1:0] e1,
                           input logic [CW-1:0] e2, input logic [CW-1:0] e3);
    check(req, {code_of(3), code_of(2), code_of(1), code_of(0)}, {e3, e2, e1, e0});
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input int ch, input logic [CW-1:0] code);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 2'(ch); wr_code = code;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic ld, input logic rs, input logic [NCH-1:0] g);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_load_bit = ld; cmd_reset_bit = rs; cmd_gain = g;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_load_bit = 1'b0; cmd_reset_bit = 1'b0;
  endtask

  task automatic pin_low_settle();
    @(negedge clk); load_n = 1'b0; wait_neg(3);
  endtask

  task automatic pin_high_settle();
    @(negedge clk); load_n = 1'b1; wait_neg(3);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    wait_neg(2); rst_n = 1'b1; wait_neg(1);
    gain_model = '1;
  endtask

  task automatic t_reset_state();
    check_all("R1 reset codes", 16'h0, 16'h0, 16'h0, 16'h0);
    check("R10 reset gain", gain_sel, 4'hF);
    check("R9 busy idle", rst_busy, 1'b0);
  endtask

  task automatic t_immediate();
    pin_low_settle();
    do_write(1, 16'h1234);
    check_all("R3 immediate ch1", 16'h0, 16'h1234, 16'h0, 16'h0);
    do_write(0, 16'hA5A5);
    check_all("R2 immediate ch0 only", 16'hA5A5, 16'h1234, 16'h0, 16'h0);
    pin_high_settle();
  endtask

  task automatic t_deferred_cmd_load();
    do_write(2, 16'hBEEF);
    check_all("R4 deferred held", 16'hA5A5, 16'h1234, 16'h0, 16'h0);
    do_cmd(1'b1, 1'b0, gain_model);
    check_all("R5 command load", 16'hA5A5, 16'h1234, 16'hBEEF, 16'h0);
    do_cmd(1'b1, 1'b0, gain_model);
    check_all("R6 clean load no change", 16'hA5A5, 16'h1234, 16'hBEEF, 16'h0);
  endtask

  task automatic t_pin_load();
    do_write(3, 16'h7001);
    @(negedge clk); load_n = 1'b0;
    wait_neg(2);
    check("R12 not before sync", code_of(3), 16'h0);
    wait_neg(1);
    check("R12 pin fall load", code_of(3), 16'h7001);
    check_all("R5 pin load others", 16'hA5A5, 16'h1234, 16'hBEEF, 16'h7001);
    pin_high_settle();
  endtask

  task automatic t_concurrent();
    do_write(2, 16'h2222);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 2'd2; wr_code = 16'h3333;
    cmd_wr = 1'b1; cmd_load_bit = 1'b1; cmd_gain = gain_model;
    @(negedge clk);
    wr_valid = 1'b0; cmd_wr = 1'b0; cmd_load_bit = 1'b0;
    check("R11 concurrent loads old", code_of(2), 16'h2222);
    do_cmd(1'b1, 1'b0, gain_model);
    check("R11 pending kept", code_of(2), 16'h3333);
  endtask

  task automatic t_gain();
    do_cmd(1'b0, 1'b0, 4'h5);
    gain_model = 4'h5;
    check("R10 gain write", gain_sel, 4'h5);
  endtask

  task automatic t_soft_reset();
    do_write(0, 16'h4444);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_reset_bit = 1'b1; cmd_gain = 4'h0;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_reset_bit = 1'b0;
    check("R9 busy raised", rst_busy, 1'b1);
    wr_valid = 1'b1; wr_chan = 2'd1; wr_code = 16'h9999;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R9 busy cleared", rst_busy, 1'b0);
    check_all("R9 soft reset clears", 16'h0, 16'h0, 16'h0, 16'h0);
    check("R10 gain after soft reset", gain_sel, 4'hF);
    gain_model = '1;
    do_cmd(1'b1, 1'b0, gain_model);
    check_all("R9 write in busy dropped", 16'h0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic t_hw_reset();
    pin_low_settle();
    do_write(1, 16'h5555);
    pin_high_settle();
    do_write(3, 16'h6666);
    do_cmd(1'b0, 1'b0, 4'h3);
    @(negedge clk); rst_n = 1'b0;
    wr_valid = 1'b1; wr_chan = 2'd2; wr_code = 16'h7777;
    @(negedge clk);
    check_all("R7 codes in reset", 16'h0, 16'h0, 16'h0, 16'h0);
    @(negedge clk); wr_valid = 1'b0; rst_n = 1'b1; gain_model = '1;
    wait_neg(2);
    check_all("R7 hold after release", 16'h0, 16'h0, 16'h0, 16'h0);
    check("R10 gain after hw reset", gain_sel, 4'hF);
    do_cmd(1'b1, 1'b0, gain_model);
    check_all("R8 pending discarded", 16'h0, 16'h0, 16'h0, 16'h0);
    pin_low_settle();
    do_write(2, 16'h0F0F);
    check_all("R7 new value after reset", 16'h0, 16'h0, 16'h0F0F, 16'h0);
    pin_high_settle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
    t_reset_state();
    t_immediate();
    t_deferred_cmd_load();
    t_pin_load();
    t_concurrent();
    t_gain();
    t_soft_reset();
    t_hw_reset();
    wait_neg(2);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule